// File: doc/BRIEF.md
# Sequential Booth Radix-2 Signed Multiplier

This block multiplies two signed two's-complement operands of width `W`. It spends one clock cycle on each multiplier bit. A pulse on `start` while the block is idle captures both operands. The multiplier is then recoded two bits at a time: the current low bit of a rotating copy, and the bit that sat there one step earlier. From that pair the block adds the multiplicand, subtracts it, or leaves the running value unchanged. It then shifts the high and low halves of the running value right together as one value, keeping the sign.

The high half is kept one bit wider than the operands, so the block can subtract the most negative multiplicand without losing the sign. The low half starts at zero and fills with product bits as the shifts proceed. The multiplier copy is rotated instead of being consumed, so no second copy of it is held.

After exactly `W` steps the block drops `busy`, pulses `done` for one cycle, and holds the 2W-bit product until the next accepted `start`. A caller pulses `start`, waits for `done`, and reads `product` in that cycle or any later idle cycle.

Top module: `booth_seq_mul`

## Requirements
- R1: While reset is high and in the first cycle after it, `busy` and `done` are 0 and `product` is all zeros.
- R2: A `start` seen while `busy` is 0 raises `busy` in the next cycle. `busy` then stays high for exactly `W` cycles.
- R3: `done` is high for exactly one cycle. That cycle is the first one in which `busy` is low again after a run, and `done` is never high together with `busy`.
- R4: In the `done` cycle, `product` equals the signed two's-complement product of the operands captured at `start`. It keeps that value in every following cycle until another `start` is accepted.
- R5: A `start` seen while `busy` is 1 has no effect: the run in progress keeps its operands, its length and its result.
- R6: The products of the extreme values are exact, including most-negative times most-negative, times -1, and times most-positive. No overflow occurs inside the subtraction of the most negative multiplicand.
- R7: Changes on `mcand` and `mplier` after the accepted `start` do not alter the result of the run in progress.
- R8: With `W`=4, every one of the 256 operand pairs gives the correct 8-bit signed product; for example, 0010 times 1100 gives 11111000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Pulse to begin a multiplication; accepted only when idle |
| mcand | input | W | Signed multiplicand |
| mplier | input | W | Signed multiplier |
| busy | output | 1 | High while the W recoding steps run |
| done | output | 1 | One-cycle pulse when the product is ready |
| product | output | 2*W | Signed product, valid from `done` until the next accepted start |

## Verification
The bench builds two instances: one at the default `W`=8 and one at `W`=4. The 8-bit instance is compared every cycle against a behavioural model of busy, done and product. It runs on corner operands (zero, -1, the most negative value and the most positive value), on random pairs, on a start asserted during a run, on operands changing mid-run, and on a restart issued in the `done` cycle. The 4-bit instance is small enough to cover the whole operand space, so every recoding sequence and sign combination at that width is reached.

// File: rtl/booth_pkg.sv
package booth_pkg;

    // Action chosen from the current/previous multiplier bit pair
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_ADD  = 2'd1,
        OP_SUB  = 2'd2
    } booth_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    // Strobes from the sequencer to the datapath
    typedef struct packed {
        logic load;
        logic step;
    } dp_ctrl_t;

    function automatic booth_op_e recode(input logic cur_bit, input logic prev_bit);
        booth_op_e op;
        case ({cur_bit, prev_bit})
            2'b01:   op = OP_ADD;
            2'b10:   op = OP_SUB;
            default: op = OP_HOLD;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/booth_step.sv
module booth_step
    import booth_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W:0]   acc,
    input  logic [W-1:0] y,
    input  logic         cur_bit,
    input  logic         prev_bit,
    output logic [W:0]   sum
);
    localparam int AW = W + 1;

    logic [AW-1:0] y_ext;
    booth_op_e     op;

    always_comb begin
        y_ext = {y[W-1], y};
        op    = recode(cur_bit, prev_bit);
        case (op)
            OP_ADD:  sum = acc + y_ext;
            OP_SUB:  sum = acc + (~y_ext) + AW'(1);
            default: sum = acc;
        endcase
    end
endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl
    import booth_pkg::*;
#(
    parameter int W = 8
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    output dp_ctrl_t ctl,
    output logic     busy,
    output logic     done
);
    localparam int CW = $clog2(W + 1);

    run_state_e    state_q;
    logic [CW-1:0] cnt_q;
    logic          done_q;

    always_comb begin
        ctl.load = (state_q == ST_IDLE) && start;
        ctl.step = (state_q == ST_RUN);
        busy     = (state_q == ST_RUN);
        done     = done_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_RUN;
                        cnt_q   <= CW'(W);
                    end
                end
                default: begin
                    cnt_q <= cnt_q - CW'(1);
                    if (cnt_q == CW'(1)) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/booth_dp.sv
module booth_dp
    import booth_pkg::*;
#(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  dp_ctrl_t       ctl,
    input  logic [W-1:0]   mcand,
    input  logic [W-1:0]   mplier,
    output logic [2*W-1:0] product
);
    logic [W-1:0] y_q;     // captured multiplicand
    logic [W:0]   hi_q;    // upper accumulator, one guard bit
    logic [W-1:0] lo_q;    // lower half, fills with product bits
    logic [W-1:0] rot_q;   // rotating multiplier copy
    logic         prev_q;  // bit examined on the previous step
    logic [W:0]   sum;

    booth_step #(.W(W)) u_step (
        .acc      (hi_q),
        .y        (y_q),
        .cur_bit  (rot_q[0]),
        .prev_bit (prev_q),
        .sum      (sum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            y_q    <= '0;
            hi_q   <= '0;
            lo_q   <= '0;
            rot_q  <= '0;
            prev_q <= 1'b0;
        end else if (ctl.load) begin
            y_q    <= mcand;
            hi_q   <= '0;
            lo_q   <= '0;
            rot_q  <= mplier;
            prev_q <= 1'b0;
        end else if (ctl.step) begin
            hi_q   <= {sum[W], sum[W:1]};
            lo_q   <= {sum[0], lo_q[W-1:1]};
            rot_q  <= {rot_q[0], rot_q[W-1:1]};
            prev_q <= rot_q[0];
        end
    end

    assign product = {hi_q[W-1:0], lo_q};
endmodule

// File: rtl/booth_seq_mul.sv
module booth_seq_mul
    import booth_pkg::*;
#(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [W-1:0]   mcand,
    input  logic [W-1:0]   mplier,
    output logic           busy,
    output logic           done,
    output logic [2*W-1:0] product
);
    dp_ctrl_t ctl;

    booth_ctrl #(.W(W)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .ctl   (ctl),
        .busy  (busy),
        .done  (done)
    );

    booth_dp #(.W(W)) u_dp (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .mcand   (mcand),
        .mplier  (mplier),
        .product (product)
    );
endmodule

// File: rtl/booth_seq_mul_chk.sv
module booth_seq_mul_chk #(
    parameter int W = 8
) (
    input logic           clk,
    input logic           rst,
    input logic           start,
    input logic           busy,
    input logic           done,
    input logic [2*W-1:0] product
);
    int run_len;

    always_ff @(posedge clk) begin
        if (rst)       run_len <= 0;
        else if (busy) run_len <= run_len + 1;
        else           run_len <= 0;
    end

    AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy); // R2

    AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (run_len == W)); // R2

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R3

    AST_DONE_AT_BUSY_FALL: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(busy) && !busy)); // R3

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        !(done && busy)); // R3

    AST_PRODUCT_HELD: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$past(busy)) |-> $stable(product)); // R4

    AST_RESET_IDLE: assert property (@(posedge clk)
        $past(rst) |-> (!busy && !done && product == '0)); // R1
endmodule

bind booth_seq_mul booth_seq_mul_chk #(.W(W)) u_chk (.*);

// File: tb/booth_seq_mul_test.sv
module booth_seq_mul_test;
    localparam int W  = 8;
    localparam int W4 = 4;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic           rst;
    logic           start;
    logic [W-1:0]   a, b;
    logic           busy, done;
    logic [2*W-1:0] product;

    logic            start4;
    logic [W4-1:0]   a4, b4;
    logic            busy4, done4;
    logic [2*W4-1:0] prod4;

    booth_seq_mul #(.W(W)) uut (
        .clk(clk), .rst(rst), .start(start), .mcand(a), .mplier(b),
        .busy(busy), .done(done), .product(product)
    );

    booth_seq_mul #(.W(W4)) uut_n4 (
        .clk(clk), .rst(rst), .start(start4), .mcand(a4), .mplier(b4),
        .busy(busy4), .done(done4), .product(prod4)
    );

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [2*W-1:0] sprod(input logic [W-1:0] x, input logic [W-1:0] y);
        int p;
        p = int'($signed(x)) * int'($signed(y));
        return p[2*W-1:0];
    endfunction

    function automatic logic [2*W4-1:0] sprod4(input logic [W4-1:0] x, input logic [W4-1:0] y);
        int p;
        p = int'($signed(x)) * int'($signed(y));
        return p[2*W4-1:0];
    endfunction

    // Behavioural cycle model of the 8-bit instance
    bit             m_busy, m_done;
    int             m_cnt;
    logic [2*W-1:0] m_prod, m_pend;

    always @(posedge clk) begin
        if (rst) begin
            m_busy <= 1'b0; m_done <= 1'b0; m_cnt <= 0;
            m_prod <= '0;   m_pend <= '0;
        end else begin
            m_done <= 1'b0;
            if (!m_busy) begin
                if (start) begin
                    m_busy <= 1'b1;
                    m_cnt  <= W;
                    m_pend <= sprod(a, b);
                end
            end else begin
                m_cnt <= m_cnt - 1;
                if (m_cnt == 1) begin
                    m_busy <= 1'b0;
                    m_done <= 1'b1;
                    m_prod <= m_pend;
                end
            end
        end
    end

    // Every-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst && !finished) begin
            check(busy == m_busy, "R2 busy", longint'(busy), longint'(m_busy));
            check(done == m_done, "R3 done", longint'(done), longint'(m_done));
            if (!m_busy)
                check(product == m_prod, "R4 product", longint'(product), longint'(m_prod));
        end
    end

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    task automatic run8(input logic [W-1:0] x, input logic [W-1:0] y, input string tag);
        @(negedge clk);
        a = x; b = y; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        check(product == sprod(x, y), tag, longint'(product), longint'(sprod(x, y)));
    endtask

    task automatic run4(input logic [W4-1:0] x, input logic [W4-1:0] y);
        @(negedge clk);
        a4 = x; b4 = y; start4 = 1'b1;
        @(negedge clk);
        start4 = 1'b0;
        while (!done4) @(negedge clk);
        check(prod4 == sprod4(x, y), "R8", longint'(prod4), longint'(sprod4(x, y)));
    endtask

    task automatic finish_up();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=finish");
        finish_up();
    end

    initial begin
        rst = 1'b1; start = 1'b0; a = '0; b = '0;
        start4 = 1'b0; a4 = '0; b4 = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: idle after reset
        check(!busy && !done, "R1 flags", longint'({busy, done}), 0);
        check(product == '0, "R1 product", longint'(product), 0);

        // R4: basic examples
        run8(8'h04, 8'h03, "R4 4*3");
        check(product == 16'h000C, "R4 const", longint'(product), 16'h000C);
        run8(8'h01, 8'h03, "R4 1*3");

        // R6: corner operand grid
        begin
            logic [W-1:0] corner [6] = '{8'h00, 8'hFF, 8'h80, 8'h7F, 8'h01, 8'h81};
            foreach (corner[i]) foreach (corner[j])
                run8(corner[i], corner[j], "R6");
        end
        run8(8'h80, 8'h80, "R6 min*min");
        check(product == 16'h4000, "R6 const", longint'(product), 16'h4000);

        // R5: start during a run is ignored
        @(negedge clk);
        a = 8'h13; b = 8'hF5; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        a = 8'h7F; b = 8'h7F; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        check(product == sprod(8'h13, 8'hF5), "R5", longint'(product), longint'(sprod(8'h13, 8'hF5)));

        // R7: operand changes after capture are ignored
        @(negedge clk);
        a = 8'hA7; b = 8'h3C; start = 1'b1;
        @(negedge clk);
        start = 1'b0; a = 8'h55; b = 8'h99;
        repeat (2) @(negedge clk);
        a = 8'h00; b = 8'hFF;
        wait_done();
        check(product == sprod(8'hA7, 8'h3C), "R7", longint'(product), longint'(sprod(8'hA7, 8'h3C)));

        // Restart issued in the done cycle (R2)
        a = 8'hE1; b = 8'h0B; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R2 restart", longint'(busy), 1);
        wait_done();
        check(product == sprod(8'hE1, 8'h0B), "R4 restart", longint'(product), longint'(sprod(8'hE1, 8'h0B)));

        // R4: random pairs
        for (int k = 0; k < 60; k++)
            run8(W'($urandom), W'($urandom), "R4 random");

        // R8: narrow instance, worked example and full space
        run4(4'b0010, 4'b1100);
        check(prod4 == 8'hF8, "R8 example", longint'(prod4), 8'hF8);
        for (int i = 0; i < 16; i++)
            for (int j = 0; j < 16; j++)
                run4(W4'(i), W4'(j));

        repeat (3) @(negedge clk);
        finish_up();
    end
endmodule